// File: doc/BRIEF.md
# Key-Locked Clock Controller Register Bank

This block is the software-visible register bank of a clock controller. A bus master reaches it through a simple synchronous port: an address, a write strobe, write data and combinational read data. Four control words drive the clock generation logic, which sits outside this block. These control words can change only while the bank is unlocked. Software unlocks the bank by writing a 16-bit key word to the key register. Any other value written there locks the bank again.

The bank also keeps a 16-bit interrupt flag word, and software can only read it. Hardware event pulses set the flags. Two write-only alias registers also change them: one clears every flag bit written as 1, and the other sets every flag bit written as 1. A 0 bit in either alias leaves its flag alone. A per-bit enable word selects which flags drive the single combined interrupt output.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, every control word, the enable word and the flag word are zero, and the bank is locked.
- R2: A write to the key register (offset 0x00) whose low 16 bits equal 0x695A unlocks the bank, whatever the upper 16 bits hold. While the bank is unlocked, reading offset 0x00 returns 0x00000001.
- R3: A write to offset 0x00 with any other low half locks the bank. While the bank is locked, reading offset 0x00 returns 0x0000A596.
- R4: While the bank is locked, writes to the control words (offsets 0x04, 0x08, 0x0C, 0x10) change neither the stored value nor the `ctrl_out` port.
- R5: While the bank is unlocked, a write to a control word stores all 32 bits. The value can be read back at the same offset, and it appears on `ctrl_out`, with word k in bits [32k+31:32k], one cycle after the write.
- R6: Writes to the flag view at offset 0x48 have no effect on the flags.
- R7: A write to the clear alias at offset 0x50 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: A write to the set alias at offset 0x58 sets each flag whose data bit is 1. Only the implemented flag bits exist: 0 to 2, 6, 8 to 10 and 12 to 15 (mask 0xF747). Every other flag bit stays 0 whatever the source.
- R9: A pulse on `hw_evt[b]` sets flag b on the next cycle. This also holds when a clear of that bit arrives in the same cycle.
- R10: `irq_out` is the OR over all bits of (flag AND enable).
- R11: The enable word at offset 0x40 can be written whether the bank is locked or not, and it stores only the implemented bits (mask 0xF747). The clear and set aliases always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 16 | One-cycle hardware event pulses, one per flag bit |
| ctrl_out | output | 128 | The four control words, packed |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following:
- A matching key write leaves the bank unlocked, and any other key write leaves it locked.
- A locked write to a control word leaves that word unchanged.
- A hardware pulse always reaches its flag.
- A clear with no competing set removes its bits.

Only the bench scenarios can show the remaining behaviour: the exact read values of the key register, the masking of unimplemented bits, the read-back of each offset, and the interaction of the enable word with the interrupt output. The bench checks these against its own model at each offset.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int FLAG_W = 16;

  localparam logic [ADDR_W-1:0] OFS_KEY   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL0 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IE    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h58;

  localparam logic [FLAG_W-1:0] FLAG_MASK = 16'hF747;
  localparam logic [15:0]       KEY_WORD  = 16'h695A;
  localparam logic [DATA_W-1:0] RD_LOCKED   = 32'h0000_A596;
  localparam logic [DATA_W-1:0] RD_UNLOCKED = 32'h0000_0001;

  // Address of control word idx: words are 4 bytes apart after the key.
  function automatic logic [ADDR_W-1:0] ctrl_addr(input int idx);
    return ADDR_W'(int'(OFS_CTRL0) + 4 * idx);
  endfunction

  // Flag update: events and sets dominate clears; unimplemented bits held at 0.
  function automatic logic [FLAG_W-1:0] flag_next(input logic [FLAG_W-1:0] cur,
                                                  input logic [FLAG_W-1:0] clr,
                                                  input logic [FLAG_W-1:0] set,
                                                  input logic [FLAG_W-1:0] evt);
    return ((cur & ~clr) | set | evt) & FLAG_MASK;
  endfunction
endpackage

// File: rtl/clkctl_keylock.sv
module clkctl_keylock
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [15:0]       key_low,
  output logic              unlocked,
  output logic [DATA_W-1:0] key_rd
);
  logic key_hit;
  logic key_miss;

  assign key_hit  = key_wr && (key_low == KEY_WORD);
  assign key_miss = key_wr && (key_low != KEY_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n)        unlocked <= 1'b0;
    else if (key_hit)  unlocked <= 1'b1;
    else if (key_miss) unlocked <= 1'b0;
  end

  assign key_rd = unlocked ? RD_UNLOCKED : RD_LOCKED;

  AST_KEY_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> unlocked); // R2
  AST_KEY_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    key_miss |=> !unlocked); // R3
endmodule

// File: rtl/clkctl_flagbank.sv
module clkctl_flagbank
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_wr,
  input  logic              clr_wr,
  input  logic              set_wr,
  input  logic [FLAG_W-1:0] wdata,
  input  logic [FLAG_W-1:0] hw_evt,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] ie,
  output logic              irq
);
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] evt_vec;

  assign clr_vec = clr_wr ? wdata : '0;
  assign set_vec = set_wr ? wdata : '0;
  assign evt_vec = hw_evt & FLAG_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      ie    <= '0;
    end else begin
      flags <= flag_next(flags, clr_vec, set_vec, evt_vec);
      if (ie_wr) ie <= wdata & FLAG_MASK;
    end
  end

  assign irq = |(flags & ie);

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt_vec)) == $past(evt_vec))); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((flags & $past(clr_vec & ~set_vec & ~evt_vec)) == '0)); // R7
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int NUM_CTRL = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [FLAG_W-1:0]          hw_evt,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_out,
  output logic                       irq_out
);
  logic                       unlocked;
  logic [DATA_W-1:0]          key_rd;
  logic [FLAG_W-1:0]          flags;
  logic [FLAG_W-1:0]          ie;
  logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q;
  logic [NUM_CTRL-1:0]        ctrl_sel;

  logic key_wr, ie_wr, clr_wr, set_wr;
  assign key_wr = bus_we && (bus_addr == OFS_KEY);
  assign ie_wr  = bus_we && (bus_addr == OFS_IE);
  assign clr_wr = bus_we && (bus_addr == OFS_CLR);
  assign set_wr = bus_we && (bus_addr == OFS_SET);

  clkctl_keylock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_low  (bus_wdata[15:0]),
    .unlocked (unlocked),
    .key_rd   (key_rd)
  );

  clkctl_flagbank u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .ie_wr  (ie_wr),
    .clr_wr (clr_wr),
    .set_wr (set_wr),
    .wdata  (bus_wdata[FLAG_W-1:0]),
    .hw_evt (hw_evt),
    .flags  (flags),
    .ie     (ie),
    .irq    (irq_out)
  );

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADDR = ctrl_addr(g);
    assign ctrl_sel[g] = (bus_addr == MY_ADDR);
    assign ctrl_out[g*DATA_W +: DATA_W] = ctrl_q[g];

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && ctrl_sel[g] && !unlocked) |=> $stable(ctrl_q[g])); // R4
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (bus_we && unlocked && ctrl_sel[i]) ctrl_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_KEY)       bus_rdata = key_rd;
    else if (bus_addr == OFS_IE)   bus_rdata = {{(DATA_W-FLAG_W){1'b0}}, ie};
    else if (bus_addr == OFS_FLAG) bus_rdata = {{(DATA_W-FLAG_W){1'b0}}, flags};
    for (int i = 0; i < NUM_CTRL; i++)
      if (ctrl_sel[i]) bus_rdata = ctrl_q[i];
  end

  AST_RESET_LOCKED: assert property (@(posedge clk)
    !rst_n |=> !unlocked); // R1
endmodule

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCTRL = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [15:0]  hw_evt = '0;
  logic [127:0] ctrl_out;
  logic         irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  bit          m_open;
  logic [31:0] m_ctrl [NCTRL];
  logic [15:0] m_ie;
  logic [15:0] m_flag;
  logic [15:0] impl_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
    .ctrl_out(ctrl_out), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_open ? 32'h1 : 32'hA596;
      8'h04: return m_ctrl[0];
      8'h08: return m_ctrl[1];
      8'h0C: return m_ctrl[2];
      8'h10: return m_ctrl[3];
      8'h40: return {16'h0, m_ie};
      8'h48: return {16'h0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  // Compare registered outputs with the model (run after every clock).
  task automatic compare_all(input string tag);
    bit any;
    for (int k = 0; k < NCTRL; k++)
      chk({tag, " R5 ctrl_out"}, ctrl_out[k*32 +: 32], m_ctrl[k]);
    any = 0;
    for (int b = 0; b < 16; b++) if (m_flag[b] && m_ie[b]) any = 1;
    chk({tag, " R10 irq_out"}, {31'h0, irq_out}, {31'h0, any});
  endtask

  // One clock with the given stimulus; model advanced alongside.
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] evt, input string tag);
    bit          n_open;
    logic [15:0] n_flag;
    bus_we = we; bus_addr = a; bus_wdata = d; hw_evt = evt;
    n_open = m_open;
    n_flag = m_flag;
    if (we) begin
      if (a == 8'h00) n_open = (d[15:0] == 16'h695A);
      if (a == 8'h50) for (int b = 0; b < 16; b++) if (d[b]) n_flag[b] = 1'b0;
      if (a == 8'h58) for (int b = 0; b < 16; b++) if (d[b]) n_flag[b] = 1'b1;
    end
    for (int b = 0; b < 16; b++) if (evt[b]) n_flag[b] = 1'b1;
    n_flag = n_flag & impl_bits;
    @(posedge clk);
    @(negedge clk);
    if (we && m_open && a >= 8'h04 && a <= 8'h10 && a[1:0] == 2'b00)
      m_ctrl[(a >> 2) - 1] = d;
    if (we && a == 8'h40) m_ie = d[15:0] & impl_bits;
    m_open = n_open;
    m_flag = n_flag;
    bus_we = 1'b0; hw_evt = '0;
    compare_all(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_addr = a; bus_we = 1'b0;
    #1;
    chk(tag, bus_rdata, model_read(a));
  endtask

  initial begin
    impl_bits = '0;
    for (int b = 0; b <= 15; b++)
      if (b <= 2 || b == 6 || (b >= 8 && b <= 10) || b >= 12) impl_bits[b] = 1'b1;
    m_open = 0; m_ie = '0; m_flag = '0;
    for (int k = 0; k < NCTRL; k++) m_ctrl[k] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1 reset");
    rd(8'h00, "R1 R3 key read locked");
    for (int k = 0; k < NCTRL; k++) rd(8'(4 + 4*k), "R1 ctrl reset");
    rd(8'h40, "R1 ie reset");
    rd(8'h48, "R1 flag reset");

    step(1, 8'h04, 32'hDEADBEEF, '0, "R4 locked write");
    rd(8'h04, "R4 locked ctrl0 unchanged");

    step(1, 8'h00, 32'hFFFF_695A, '0, "R2 unlock");
    rd(8'h00, "R2 key read unlocked");
    for (int k = 0; k < NCTRL; k++)
      step(1, 8'(4 + 4*k), 32'h1111_0000 * (k + 1) + 32'h00C3 + k, '0, "R5 write");
    for (int k = 0; k < NCTRL; k++) rd(8'(4 + 4*k), "R5 ctrl readback");

    step(1, 8'h00, 32'h0000_1234, '0, "R3 relock");
    rd(8'h00, "R3 key read relocked");
    step(1, 8'h08, 32'h5555_AAAA, '0, "R4 locked write ctrl1");
    rd(8'h08, "R4 ctrl1 unchanged");

    step(1, 8'h48, 32'hFFFF_FFFF, '0, "R6 write flag view");
    rd(8'h48, "R6 flags untouched");

    step(1, 8'h58, 32'hFFFF_FFFF, '0, "R8 set all");
    rd(8'h48, "R8 flags masked F747");
    rd(8'h58, "R11 set alias reads 0");
    rd(8'h50, "R11 clear alias reads 0");

    step(1, 8'h50, 32'h0000_0003, '0, "R7 clear two");
    rd(8'h48, "R7 partial clear");
    step(1, 8'h50, 32'h0, '0, "R7 clear zero");
    rd(8'h48, "R7 zero write no effect");
    step(1, 8'h58, 32'h0, '0, "R8 set zero");
    rd(8'h48, "R8 zero write no effect");

    step(1, 8'h40, 32'hFFFF_FFFF, '0, "R11 ie write locked");
    rd(8'h40, "R11 ie masked");
    step(1, 8'h50, 32'hFFFF, '0, "R10 clear all");
    step(1, 8'h40, 32'h0000_0100, '0, "R11 ie bit8");
    step(0, 8'h00, 32'h0, 16'h0200, "R10 masked evt no irq");
    step(0, 8'h00, 32'h0, 16'h0100, "R9 R10 evt bit8");
    rd(8'h48, "R9 event set");
    step(1, 8'h50, 32'h0000_0100, 16'h0100, "R9 evt beats clear");
    rd(8'h48, "R9 flag kept");
    step(1, 8'h50, 32'h0000_0100, '0, "R7 clear bit8");
    step(0, 8'h00, 32'h0, 16'h0008, "R8 unimplemented evt");
    rd(8'h48, "R8 bit3 stays 0");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule